// File: doc/BRIEF.md
# Translation-Table Base and Context Configuration Register Bank

This block keeps the translation-table base registers and the context configuration registers for both memory-management units of a core. The instruction-side unit and the data-side unit each have four base registers and two context configuration registers, 64 bits apiece. Software updates them through stores that carry an 8-bit address-space identifier and 64 bits of data. The block turns the sparse identifier codes into a register select and writes the chosen register on the next rising clock edge.

All twelve registers drive parallel outputs, so the pointer generator next to this block can read them at any time. A separate combinational read port returns any one of them by identifier. The registers can only be written in privileged mode. When the hypervisor-mode input is low, a store to one of these identifiers changes nothing and raises an illegal-instruction trap pulse instead.

The block is a flat decode with no sequencing of its own. It has a single operating state, "ready". Every cycle leaves the block in that state through one of three transitions: "commit" (a permitted write), "refuse" (a gated write, which also traps) or "idle" (no write, or an identifier outside the set).

Top module: `tsb_cfg_bank`

## Requirements
- R1: While reset is asserted (active low, asynchronous), all twelve registers are zero. After reset is released they read zero until they are written.
- R2: With hypervisor mode on, identifiers 0x31, 0x32, 0x39 and 0x3A write data-side base registers 0, 1, 2 and 3. The index is {identifier bit 3, identifier bit 1}. The new value appears on the next rising edge.
- R3: With hypervisor mode on, identifiers 0x35, 0x36, 0x3D and 0x3E write instruction-side base registers 0, 1, 2 and 3, using the same index rule as R2.
- R4: With hypervisor mode on, identifiers 0x33 and 0x3B write data-side context configuration registers 0 and 1, and identifiers 0x37 and 0x3F write the instruction-side ones. The index is identifier bit 3: 0 selects context zero and 1 selects nonzero contexts.
- R5: With hypervisor mode off, a write strobe to any of the twelve identifiers leaves every register unchanged and drives the trap output high in that same cycle.
- R6: The trap output is high only in a cycle with a write strobe, hypervisor mode off and an identifier from the twelve-code set. It is low in every other cycle.
- R7: A permitted write changes only the register it addresses. A later write to the same identifier replaces the earlier value.
- R8: The read port returns the current value of the register that its identifier selects, using the same code map as R2 to R4, in the same cycle. Any other identifier (for example 0x30, 0x34, 0x38, 0x3C or 0x40) reads as zero.
- R9: A write to an identifier outside the twelve-code set changes no register and raises no trap, whatever the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| hv_en | input | 1 | Hypervisor mode; high permits writes |
| wr_en | input | 1 | Write strobe |
| wr_asi | input | 8 | Address-space identifier of the write |
| wr_data | input | 64 | Write data |
| trap_ill_o | output | 1 | Illegal-instruction trap pulse, same cycle as the strobe |
| rd_asi | input | 8 | Address-space identifier of the read |
| rd_data_o | output | 64 | Read data, combinational |
| dmmu_base_o | output | 4x64 | Data-side base registers, index 0 in the low word |
| dmmu_cfg_o | output | 2x64 | Data-side context configuration, index 0 is context zero |
| immu_base_o | output | 4x64 | Instruction-side base registers |
| immu_cfg_o | output | 2x64 | Instruction-side context configuration |

## Verification
The properties assume that the write strobe, mode flag and identifiers have known values at every sampled edge after reset. They also assume the write strobe stays low during reset, so that a comparison one cycle back never reaches a store issued during reset. The stimulus changes every input one nanosecond after a rising edge and gives each input a defined value from time zero. It holds the write strobe low until reset has been released. It then walks through all twelve codes, the gaps between them and a foreign high nibble, in both modes.

// File: rtl/tsb_cfg_pkg.sv
package tsb_cfg_pkg;

    localparam int ASI_W = 8;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_BASE = 2'd1,
        SEL_CFG  = 2'd2
    } sel_kind_e;

    typedef struct packed {
        sel_kind_e  kind;
        logic       inst;   // 1: instruction side, 0: data side
        logic [1:0] idx;
    } asi_dec_t;

    // Sparse code map: high nibble 3, low bits pick base or config,
    // bit 2 picks the side, bits 3 and 1 form the register index.
    function automatic asi_dec_t decode_asi(input logic [ASI_W-1:0] asi);
        asi_dec_t d;
        d.kind = SEL_NONE;
        d.inst = asi[2];
        d.idx  = 2'b00;
        if (asi[ASI_W-1:4] == 4'h3) begin
            unique case (asi[1:0])
                2'b01, 2'b10: begin
                    d.kind = SEL_BASE;
                    d.idx  = {asi[3], asi[1]};
                end
                2'b11: begin
                    d.kind = SEL_CFG;
                    d.idx  = {1'b0, asi[3]};
                end
                default: d.kind = SEL_NONE;
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/tsb_asi_decode.sv
module tsb_asi_decode
    import tsb_cfg_pkg::*;
(
    input  logic [ASI_W-1:0] asi,
    output asi_dec_t         dec_o
);
    always_comb begin
        dec_o = decode_asi(asi);
    end
endmodule

// File: rtl/tsb_reg_file.sv
module tsb_reg_file #(
    parameter int DATA_W = 64,
    parameter int N_BASE = 4,
    parameter int N_CFG  = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we_base,
    input  logic [$clog2(N_BASE)-1:0]      base_idx,
    input  logic                           we_cfg,
    input  logic [$clog2(N_CFG)-1:0]       cfg_idx,
    input  logic [DATA_W-1:0]              wdata,
    output logic [N_BASE-1:0][DATA_W-1:0]  base_o,
    output logic [N_CFG-1:0][DATA_W-1:0]   cfg_o
);
    logic [N_BASE-1:0][DATA_W-1:0] base_q;
    logic [N_CFG-1:0][DATA_W-1:0]  cfg_q;

    for (genvar b = 0; b < N_BASE; b++) begin : g_base
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                base_q[b] <= '0;
            end else if (we_base && (base_idx == b)) begin
                base_q[b] <= wdata;
            end
        end
    end

    for (genvar c = 0; c < N_CFG; c++) begin : g_cfg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_q[c] <= '0;
            end else if (we_cfg && (cfg_idx == c)) begin
                cfg_q[c] <= wdata;
            end
        end
    end

    assign base_o = base_q;
    assign cfg_o  = cfg_q;
endmodule

// File: rtl/tsb_cfg_bank.sv
module tsb_cfg_bank
    import tsb_cfg_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int N_BASE = 4,
    parameter int N_CFG  = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           hv_en,
    input  logic                           wr_en,
    input  logic [7:0]                     wr_asi,
    input  logic [DATA_W-1:0]              wr_data,
    output logic                           trap_ill_o,
    input  logic [7:0]                     rd_asi,
    output logic [DATA_W-1:0]              rd_data_o,
    output logic [N_BASE-1:0][DATA_W-1:0]  dmmu_base_o,
    output logic [N_CFG-1:0][DATA_W-1:0]   dmmu_cfg_o,
    output logic [N_BASE-1:0][DATA_W-1:0]  immu_base_o,
    output logic [N_CFG-1:0][DATA_W-1:0]   immu_cfg_o
);
    localparam int BIDX_W = $clog2(N_BASE);
    localparam int CIDX_W = $clog2(N_CFG);
    localparam int N_MMU  = 2;

    typedef enum logic [1:0] {
        ACT_IDLE   = 2'd0,
        ACT_COMMIT = 2'd1,
        ACT_REFUSE = 2'd2
    } act_e;

    asi_dec_t wr_dec, rd_dec;
    act_e     act;

    tsb_asi_decode u_wr_dec (.asi(wr_asi), .dec_o(wr_dec));
    tsb_asi_decode u_rd_dec (.asi(rd_asi), .dec_o(rd_dec));

    // Action taken in the single "ready" state this cycle.
    always_comb begin
        if (!wr_en || (wr_dec.kind == SEL_NONE)) begin
            act = ACT_IDLE;
        end else if (hv_en) begin
            act = ACT_COMMIT;
        end else begin
            act = ACT_REFUSE;
        end
    end

    logic [N_MMU-1:0][N_BASE-1:0][DATA_W-1:0] base_q;
    logic [N_MMU-1:0][N_CFG-1:0][DATA_W-1:0]  cfg_q;

    for (genvar m = 0; m < N_MMU; m++) begin : g_mmu
        logic we_base, we_cfg;
        assign we_base = (act == ACT_COMMIT) && (wr_dec.kind == SEL_BASE)
                         && (wr_dec.inst == m[0]);
        assign we_cfg  = (act == ACT_COMMIT) && (wr_dec.kind == SEL_CFG)
                         && (wr_dec.inst == m[0]);

        tsb_reg_file #(
            .DATA_W (DATA_W),
            .N_BASE (N_BASE),
            .N_CFG  (N_CFG)
        ) u_rf (
            .clk      (clk),
            .rst_n    (rst_n),
            .we_base  (we_base),
            .base_idx (wr_dec.idx[BIDX_W-1:0]),
            .we_cfg   (we_cfg),
            .cfg_idx  (wr_dec.idx[CIDX_W-1:0]),
            .wdata    (wr_data),
            .base_o   (base_q[m]),
            .cfg_o    (cfg_q[m])
        );
    end

    // Output process.
    always_comb begin
        trap_ill_o = (act == ACT_REFUSE);
        rd_data_o  = '0;
        unique case (rd_dec.kind)
            SEL_BASE: rd_data_o = base_q[rd_dec.inst][rd_dec.idx[BIDX_W-1:0]];
            SEL_CFG:  rd_data_o = cfg_q[rd_dec.inst][rd_dec.idx[CIDX_W-1:0]];
            default:  rd_data_o = '0;
        endcase
    end

    assign dmmu_base_o = base_q[0];
    assign dmmu_cfg_o  = cfg_q[0];
    assign immu_base_o = base_q[1];
    assign immu_cfg_o  = cfg_q[1];
endmodule

// File: rtl/tsb_cfg_bank_chk.sv
module tsb_cfg_bank_chk #(
    parameter int DATA_W = 64,
    parameter int N_BASE = 4,
    parameter int N_CFG  = 2
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           hv_en,
    input logic                           wr_en,
    input logic [7:0]                     wr_asi,
    input logic [DATA_W-1:0]              wr_data,
    input logic                           trap_ill_o,
    input logic [7:0]                     rd_asi,
    input logic [DATA_W-1:0]              rd_data_o,
    input logic [N_BASE-1:0][DATA_W-1:0]  dmmu_base_o,
    input logic [N_CFG-1:0][DATA_W-1:0]   dmmu_cfg_o,
    input logic [N_BASE-1:0][DATA_W-1:0]  immu_base_o,
    input logic [N_CFG-1:0][DATA_W-1:0]   immu_cfg_o
);
    logic wr_ours, rd_ours;
    assign wr_ours = wr_asi inside {8'h31, 8'h32, 8'h39, 8'h3A, 8'h35, 8'h36,
                                    8'h3D, 8'h3E, 8'h33, 8'h3B, 8'h37, 8'h3F};
    assign rd_ours = rd_asi inside {8'h31, 8'h32, 8'h39, 8'h3A, 8'h35, 8'h36,
                                    8'h3D, 8'h3E, 8'h33, 8'h3B, 8'h37, 8'h3F};

    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (dmmu_base_o == '0 && immu_base_o == '0
                          && dmmu_cfg_o == '0 && immu_cfg_o == '0));

    a_r2_dbase_top: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hv_en && wr_asi == 8'h3A) |=> dmmu_base_o[3] == $past(wr_data));

    a_r3_ibase_low: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hv_en && wr_asi == 8'h35) |=> immu_base_o[0] == $past(wr_data));

    a_r4_dcfg_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hv_en && wr_asi == 8'h3B) |=> dmmu_cfg_o[1] == $past(wr_data));

    a_r4_icfg_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hv_en && wr_asi == 8'h37) |=> immu_cfg_o[0] == $past(wr_data));

    a_r5_gated_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hv_en) |=> ($stable(dmmu_base_o) && $stable(immu_base_o)
                               && $stable(dmmu_cfg_o) && $stable(immu_cfg_o)));

    a_r5_trap_raised: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hv_en && wr_ours) |-> trap_ill_o);

    a_r6_trap_cause: assert property (@(posedge clk) disable iff (!rst_n)
        trap_ill_o |-> (wr_en && !hv_en && wr_ours));

    a_r8_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_ours |-> rd_data_o == '0);

    a_r9_foreign_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_ours) |=> ($stable(dmmu_base_o) && $stable(immu_base_o)
                                 && $stable(dmmu_cfg_o) && $stable(immu_cfg_o)));
endmodule

bind tsb_cfg_bank tsb_cfg_bank_chk #(
    .DATA_W (DATA_W),
    .N_BASE (N_BASE),
    .N_CFG  (N_CFG)
) u_chk (.*);

// File: tb/sim_tsb_cfg_bank.sv
`timescale 1ns/1ps
module sim_tsb_cfg_bank;
    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            hv_en = 1'b0;
    logic            wr_en = 1'b0;
    logic [7:0]      wr_asi = 8'h00;
    logic [63:0]     wr_data = 64'h0;
    logic [7:0]      rd_asi = 8'h00;
    logic            trap_ill_o;
    logic [63:0]     rd_data_o;
    logic [3:0][63:0] dmmu_base_o, immu_base_o;
    logic [1:0][63:0] dmmu_cfg_o, immu_cfg_o;

    always #2.5 clk = ~clk;

    tsb_cfg_bank u0 (
        .clk(clk), .rst_n(rst_n), .hv_en(hv_en), .wr_en(wr_en),
        .wr_asi(wr_asi), .wr_data(wr_data), .trap_ill_o(trap_ill_o),
        .rd_asi(rd_asi), .rd_data_o(rd_data_o),
        .dmmu_base_o(dmmu_base_o), .dmmu_cfg_o(dmmu_cfg_o),
        .immu_base_o(immu_base_o), .immu_cfg_o(immu_cfg_o)
    );

    typedef struct {
        string        req;
        int           kind;   // 0 read port, 1 trap, 2 all registers
        logic [767:0] exp;
    } item_t;

    item_t       q[$];
    logic [63:0] m [12];
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // Slot order: data base 0-3, data cfg 4-5, inst base 6-9, inst cfg 10-11.
    function automatic int slot(input logic [7:0] a);
        case (a)
            8'h31: return 0;  8'h32: return 1;  8'h39: return 2;  8'h3A: return 3;
            8'h33: return 4;  8'h3B: return 5;
            8'h35: return 6;  8'h36: return 7;  8'h3D: return 8;  8'h3E: return 9;
            8'h37: return 10; 8'h3F: return 11;
            default: return -1;
        endcase
    endfunction

    task automatic step(input string req, input bit wr, input bit hv,
                        input logic [7:0] wa, input logic [63:0] wd,
                        input logic [7:0] ra);
        item_t it;
        int s, r;
        @(posedge clk); #1;
        wr_en = wr; hv_en = hv; wr_asi = wa; wr_data = wd; rd_asi = ra;
        s = slot(wa);
        r = slot(ra);
        it.req = req; it.kind = 0; it.exp = '0;
        if (r >= 0) it.exp[63:0] = m[r];
        q.push_back(it);
        it.kind = 1; it.exp = '0; it.exp[0] = wr && !hv && (s >= 0);
        q.push_back(it);
        it.kind = 2;
        for (int i = 0; i < 12; i++) it.exp[i*64 +: 64] = m[i];
        q.push_back(it);
        if (wr && hv && s >= 0) m[s] = wd;
    endtask

    // Monitor: compares at the falling edge, away from register updates.
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                item_t it;
                logic [767:0] act;
                it = q.pop_front();
                act = '0;
                case (it.kind)
                    0: act[63:0] = rd_data_o;
                    1: act[0] = trap_ill_o;
                    default: act = {immu_cfg_o, immu_base_o, dmmu_cfg_o, dmmu_base_o};
                endcase
                total++;
                if (act !== it.exp) begin
                    bad++;
                    if (it.kind == 2)
                        $display("FAIL %s registers: actual=%h expected=%h", it.req, act, it.exp);
                    else
                        $display("FAIL %s kind%0d: actual=%h expected=%h", it.req, it.kind,
                                 act[63:0], it.exp[63:0]);
                end
            end
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] ids [12];
        logic [7:0] gaps [6];
        for (int i = 0; i < 12; i++) m[i] = 64'h0;
        ids  = '{8'h31, 8'h32, 8'h39, 8'h3A, 8'h33, 8'h3B,
                 8'h35, 8'h36, 8'h3D, 8'h3E, 8'h37, 8'h3F};
        gaps = '{8'h30, 8'h34, 8'h38, 8'h3C, 8'h40, 8'h00};
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        step("R1", 0, 0, 8'h00, 64'h0, 8'h31);
        step("R1", 0, 1, 8'h00, 64'h0, 8'h3F);

        // R2 R3 R4: permitted writes to every code, read back next cycle (R8)
        for (int i = 0; i < 12; i++) begin
            string rq;
            rq = (i < 4) ? "R2" : (i < 6) ? "R4" : (i < 10) ? "R3" : "R4";
            step(rq, 1, 1, ids[i], {8'hA0 + 8'(i), 56'h1234_5678_9ABC_DE} ^ 64'(i*977),
                 ids[i]);
        end
        for (int i = 0; i < 12; i++) step("R8", 0, 1, 8'h00, 64'h0, ids[i]);
        for (int i = 0; i < 6; i++) step("R8", 0, 1, 8'h00, 64'h0, gaps[i]);

        // R5: gated writes keep registers and trap
        step("R5", 1, 0, 8'h31, 64'hDEAD_0000_0000_0001, 8'h31);
        step("R5", 1, 0, 8'h3B, 64'hDEAD_0000_0000_0002, 8'h3B);
        step("R5", 1, 0, 8'h3E, 64'hDEAD_0000_0000_0003, 8'h3E);
        step("R5", 1, 0, 8'h37, 64'hDEAD_0000_0000_0004, 8'h37);
        step("R5", 0, 1, 8'h00, 64'h0, 8'h31);

        // R6: no trap without strobe, with mode on, or for foreign codes
        step("R6", 0, 0, 8'h32, 64'hFFFF, 8'h32);
        step("R6", 1, 0, 8'h34, 64'hFFFF, 8'h34);
        step("R6", 1, 0, 8'h73, 64'hFFFF, 8'h73);

        // R9: foreign codes change nothing
        for (int i = 0; i < 6; i++) step("R9", 1, 1, gaps[i], 64'h5555_AAAA_5555_AAAA, gaps[i]);
        step("R9", 1, 1, 8'h71, 64'h1, 8'h31);
        step("R9", 1, 1, 8'hB3, 64'h2, 8'h33);
        step("R9", 0, 1, 8'h00, 64'h0, 8'h71);

        // R7: overwrite one register, neighbours untouched
        step("R7", 1, 1, 8'h39, 64'h0123_4567_89AB_CDEF, 8'h39);
        step("R7", 1, 1, 8'h39, 64'hFEDC_BA98_7654_3210, 8'h39);
        step("R7", 1, 1, 8'h3D, 64'h0, 8'h3A);
        step("R7", 0, 1, 8'h00, 64'h0, 8'h39);
        step("R7", 0, 1, 8'h00, 64'h0, 8'h3D);

        // R1: reset clears written state
        @(posedge clk); #1 rst_n = 1'b0;
        for (int i = 0; i < 12; i++) m[i] = 64'h0;
        @(posedge clk); #1 rst_n = 1'b1;
        step("R1", 0, 1, 8'h00, 64'h0, 8'h3E);

        @(posedge clk); #1 wr_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule